// File: doc/BRIEF.md
# Double-Sampling Pipeline Stage Register with In-Place Timing Repair

This block is one register stage of a pipeline that checks its own timing. It takes the incoming word twice. The main register captures the word on the clock edge. A shadow register captures the value the data line settled to later, which a delayed strobe presents. The late value is correct by design. When the two copies of a valid slot differ, the stage makes the downstream slot a bubble, reports which lanes disagreed, and reloads the main register from the shadow copy. A flush request then goes upstream through a stabilizer chain.

Recovery stays local. The stage exchanges control signals only with its two neighbours. After an error it emits the repaired word for one cycle. It then discards incoming slots until the stabilizer chain has drained, so the flushed upstream stage can restart cleanly. For a stage that feeds architectural state, the late check can be switched off with a parameter. That stage then never raises an error and behaves as a plain valid/data register.

Top module: `late_check_stage`

## Requirements
- R1: After reset, out_valid, err_pulse, bubble, flush_up and err_sticky are all 0.
- R2: A valid slot whose late copy matches, or whose strobe is low, appears on out_data with out_valid=1 in the cycle after the capturing edge. A slot with in_valid=0 never produces out_valid=1.
- R3: When a valid slot is captured with late_stb=1 and late_data differs from in_data, err_pulse and bubble are 1 for exactly the following cycle. In that cycle out_valid is 0 and out_data still shows the early sample.
- R4: In the cycle after err_pulse, out_valid is 1 and out_data equals the late value: the main register is repaired from the shadow copy.
- R5: flush_up is a one-cycle pulse that starts STAB_DEPTH cycles after err_pulse (one cycle with the default of 1).
- R6: Slots presented at the error edge, and while the stabilizer chain holds the error, are discarded. With the default depth, out_valid is 0 in the cycle after flush_up.
- R7: A mismatch between in_data and late_data on a slot with in_valid=0 raises no error and no flush.
- R8: With late_stb=0 the shadow copy takes in_data, so a differing late_data raises no error.
- R9: err_sticky becomes 1 the cycle after the first err_pulse and stays 1 until reset.
- R10: err_lanes bit i is 1 during err_pulse when bits [i*LANE_W+LANE_W-1 : i*LANE_W] of the two copies differ (LANE_W = W/LANES, 4 by default). Every bit is 0 when err_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | W | Word sampled on the clock edge |
| in_valid | input | 1 | Slot carries a real item |
| late_data | input | W | Value the data line settled to by the delayed sample |
| late_stb | input | 1 | Delayed sample taken for this slot |
| out_data | output | W | Main register contents |
| out_valid | output | 1 | Downstream slot is valid |
| err_pulse | output | 1 | Timing error detected in the held slot |
| err_lanes | output | LANES | Lanes whose two copies disagree |
| bubble | output | 1 | Held slot is turned into a bubble downstream |
| flush_up | output | 1 | Stabilized flush request to the upstream stage |
| err_sticky | output | 1 | At least one error since reset |

## Verification
A shadow register that fails to hold its value during repair shows up the cycle after err_pulse. Either the repaired word on out_data is wrong, or a second error pulse appears. A stabilizer chain or hold path that is off by one shows up within two cycles of the error, because flush_up falls in the wrong cycle or a discarded slot reaches out_valid. The scoreboard catches a lost or duplicated item at the next valid output, and again at the final empty-queue check.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   // recovery phase as seen from the stage
   typedef enum logic [1:0] {
      DSR_RUN    = 2'd0,
      DSR_REPAIR = 2'd1,
      DSR_DRAIN  = 2'd2
   } dsr_phase_e;

   function automatic int dsr_lane_width(input int width, input int lanes);
      return width / lanes;
   endfunction
endpackage

// File: rtl/dsr_capture.sv
module dsr_capture #(
   parameter int W        = 16,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic         vld_in,
   input  logic [W-1:0] late_d,
   input  logic         late_stb,
   input  logic         restore,
   input  logic         hold,
   output logic [W-1:0] main_q,
   output logic [W-1:0] shad_q,
   output logic         vld_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q <= '0;
         vld_q  <= 1'b0;
      end else if (restore) begin
         main_q <= shad_q;
      end else if (hold) begin
         vld_q  <= 1'b0;
      end else begin
         main_q <= d;
         vld_q  <= vld_in;
      end
   end

   generate
      if (CHECK_EN) begin : g_shadow
         logic [W-1:0] shad_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shad_r <= '0;
            else if (!restore && !hold)
               shad_r <= late_stb ? late_d : d;
         end
         assign shad_q = shad_r;
      end else begin : g_plain
         logic unused_late;
         assign unused_late = ^{late_d, late_stb};
         assign shad_q = main_q;
      end
   endgenerate
endmodule

// File: rtl/dsr_compare.sv
module dsr_compare #(
   parameter int W     = 16,
   parameter int LANES = 4
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic             qual,
   output logic [LANES-1:0] lane_miss,
   output logic             any_miss
);
   localparam int LW = dsr_pkg::dsr_lane_width(W, LANES);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_miss[i] = qual && (a[i*LW +: LW] != b[i*LW +: LW]);
   end

   assign any_miss = |lane_miss;
endmodule

// File: rtl/dsr_stabilizer.sv
module dsr_stabilizer #(
   parameter int DEPTH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic busy
);
   logic [DEPTH-1:0] chain;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[DEPTH-2:0], d};
         end
      end
   endgenerate

   assign q    = chain[DEPTH-1];
   assign busy = |chain;
endmodule

// File: rtl/late_check_stage.sv
module late_check_stage #(
   parameter int W          = 16,
   parameter int LANES      = 4,
   parameter int STAB_DEPTH = 1,
   parameter bit CHECK_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     in_data,
   input  logic             in_valid,
   input  logic [W-1:0]     late_data,
   input  logic             late_stb,
   output logic [W-1:0]     out_data,
   output logic             out_valid,
   output logic             err_pulse,
   output logic [LANES-1:0] err_lanes,
   output logic             bubble,
   output logic             flush_up,
   output logic             err_sticky
);
   import dsr_pkg::*;

   generate
      if (W < 1 || LANES < 1 || (W % LANES) != 0) begin : g_bad_lanes
         $error("late_check_stage: W must be a positive multiple of LANES");
      end
      if (STAB_DEPTH < 1) begin : g_bad_depth
         $error("late_check_stage: STAB_DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]     main_q, shad_q;
   logic             vld_q;
   logic [LANES-1:0] miss_lanes;
   logic             miss;
   logic             stab_q, stab_busy;
   logic             sticky_q;
   dsr_phase_e       phase;

   always_comb begin
      if (miss)           phase = DSR_REPAIR;
      else if (stab_busy) phase = DSR_DRAIN;
      else                phase = DSR_RUN;
   end

   dsr_capture #(.W(W), .CHECK_EN(CHECK_EN)) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .d        (in_data),
      .vld_in   (in_valid),
      .late_d   (late_data),
      .late_stb (late_stb),
      .restore  (phase == DSR_REPAIR),
      .hold     (phase == DSR_DRAIN),
      .main_q   (main_q),
      .shad_q   (shad_q),
      .vld_q    (vld_q)
   );

   dsr_compare #(.W(W), .LANES(LANES)) cmp_i (
      .a         (main_q),
      .b         (shad_q),
      .qual      (vld_q),
      .lane_miss (miss_lanes),
      .any_miss  (miss)
   );

   dsr_stabilizer #(.DEPTH(STAB_DEPTH)) stab_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (miss),
      .q     (stab_q),
      .busy  (stab_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sticky_q <= 1'b0;
      else if (miss) sticky_q <= 1'b1;
   end

   assign out_data   = main_q;
   assign out_valid  = vld_q && !miss;
   assign err_pulse  = miss;
   assign err_lanes  = miss_lanes;
   assign bubble     = vld_q && miss;
   assign flush_up   = stab_q;
   assign err_sticky = sticky_q;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
   parameter int STAB_DEPTH = 1,
   parameter int LANES      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             err_pulse,
   input logic [LANES-1:0] err_lanes,
   input logic             bubble,
   input logic             flush_up,
   input logic             err_sticky
);
   a_r3_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);
   a_r3_err_kills_slot: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (!out_valid && bubble));
   a_r4_repair_valid: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> out_valid);
   a_r5_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
      flush_up |=> !flush_up);
   a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);
   a_r9_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> err_sticky);
   a_r10_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !err_pulse |-> (err_lanes == '0));

   generate
      if (STAB_DEPTH == 1) begin : g_d1
         a_r5_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
            err_pulse |=> flush_up);
         a_r6_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
            flush_up |=> !out_valid);
      end
   endgenerate
endmodule

bind late_check_stage dsr_checker #(.STAB_DEPTH(STAB_DEPTH), .LANES(LANES)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .err_pulse  (err_pulse),
   .err_lanes  (err_lanes),
   .bubble     (bubble),
   .flush_up   (flush_up),
   .err_sticky (err_sticky)
);

// File: tb/late_check_stage_tb_top.sv
`timescale 1ns/1ps
module late_check_stage_tb_top;
   localparam int W = 16;
   localparam int L = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] in_data = '0, late_data = '0;
   logic         in_valid = 1'b0, late_stb = 1'b0;
   logic [W-1:0] out_data;
   logic [L-1:0] err_lanes;
   logic         out_valid, err_pulse, bubble, flush_up, err_sticky;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   logic [W-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   late_check_stage #(.W(W), .LANES(L), .STAB_DEPTH(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .late_data(late_data), .late_stb(late_stb), .out_data(out_data),
      .out_valid(out_valid), .err_pulse(err_pulse), .err_lanes(err_lanes),
      .bubble(bubble), .flush_up(flush_up), .err_sticky(err_sticky));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // driver: present one slot at a negedge, return at the next negedge
   task automatic drive(input logic [W-1:0] d, input logic [W-1:0] l,
                        input logic stb, input logic v, input logic expect_out);
      in_data = d; late_data = l; late_stb = stb; in_valid = v;
      if (expect_out) exp_q.push_back((stb && v) ? l : d);
      @(negedge clk);
   endtask

   // monitor: scoreboard compare of every valid output slot (R2, R4)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected valid slot", 32'(out_data), 32'hFFFF_FFFF);
         end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            check("R2/R4 scoreboard data", 32'(out_data), 32'(e));
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         check("watchdog", 32'd1, 32'd0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid", 32'(out_valid), 0);
      check("R1 err_pulse", 32'(err_pulse), 0);
      check("R1 bubble", 32'(bubble), 0);
      check("R1 flush_up", 32'(flush_up), 0);
      check("R1 err_sticky", 32'(err_sticky), 0);

      // R2 clean traffic, including an idle slot
      drive(16'h1111, 16'h1111, 1'b1, 1'b1, 1'b1);
      check("R2 valid", 32'(out_valid), 1);
      drive(16'h2222, 16'h2222, 1'b1, 1'b1, 1'b1);
      drive(16'h3333, 16'h3333, 1'b0, 1'b0, 1'b0);
      check("R2 idle slot invalid", 32'(out_valid), 0);

      // R8 strobe low: late value ignored
      drive(16'h4444, 16'h0F0F, 1'b0, 1'b1, 1'b1);
      check("R8 no error", 32'(err_pulse), 0);
      check("R8 data kept", 32'(out_data), 32'h4444);

      // R7 mismatch on an invalid slot
      drive(16'h5555, 16'h5A55, 1'b1, 1'b0, 1'b0);
      check("R7 no error", 32'(err_pulse), 0);
      drive(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
      check("R7 no flush", 32'(flush_up), 0);

      // R3 timing error in lane 2
      drive(16'h1234, 16'h1A34, 1'b1, 1'b1, 1'b1);
      check("R3 err_pulse", 32'(err_pulse), 1);
      check("R3 bubble", 32'(bubble), 1);
      check("R3 slot killed", 32'(out_valid), 0);
      check("R3 early data shown", 32'(out_data), 32'h1234);
      check("R10 lanes", 32'(err_lanes), 32'b0100);
      // R6 this slot arrives at the error edge and is dropped
      drive(16'h7777, 16'h7777, 1'b1, 1'b1, 1'b0);
      check("R4 repaired valid", 32'(out_valid), 1);
      check("R4 repaired data", 32'(out_data), 32'h1A34);
      check("R3 single pulse", 32'(err_pulse), 0);
      check("R5 flush", 32'(flush_up), 1);
      drive(16'h8888, 16'h8888, 1'b1, 1'b1, 1'b0);
      check("R6 drained slot", 32'(out_valid), 0);
      check("R5 flush single", 32'(flush_up), 0);
      check("R9 sticky set", 32'(err_sticky), 1);
      check("R10 lanes quiet", 32'(err_lanes), 0);
      drive(16'h9999, 16'h9999, 1'b1, 1'b1, 1'b1);
      check("R2 resumes", 32'(out_valid), 1);

      // R10 two lanes at the edges
      drive(16'hFFFF, 16'h0FF0, 1'b1, 1'b1, 1'b1);
      check("R10 lanes 0 and 3", 32'(err_lanes), 32'b1001);
      drive(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
      check("R4 second repair", 32'(out_data), 32'h0FF0);
      drive(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
      check("R9 sticky held", 32'(err_sticky), 1);
      drive(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
      check("R2 queue drained", exp_q.size(), 0);

      // R9 cleared only by reset
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 sticky cleared", 32'(err_sticky), 0);
      check("R1 valid after reset", 32'(out_valid), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule